// File: doc/BRIEF.md
# Code Memory Lock Guard

This block turns the three one-time lock bits of a small microcontroller into permission decisions for code-memory accesses. Each lock bit is either blank (0) or programmed (1). The number of lock bits that are set, counted from the first bit up, gives a protection level. Each level keeps every restriction of the level below it and adds one more. Any lock pattern that is not one of the four legal patterns is treated as the strictest level.

The CPU side raises one request per kind of access:
- a table read, with a flag telling whether the code doing the read runs from external memory;
- a flash program cycle;
- a flash verify cycle;
- an external-execution request.

One clock later the block answers with a registered grant for each request. For a table read it also returns the internal byte, or 00H when the read is refused.

The block also drives the effective external-access level. While the first lock bit is blank, that level follows the external-access pin. Once the first lock bit is programmed, the level is frozen to the pin value captured during reset.

Top module: `code_guard`

## Requirements
- R1: While `rst` is high, every grant output is 0 and `tbl_data` is 00H on the clock edge that follows.
- R2: With `lock_bits` = 3'b000 (bit 0 is the first lock bit, 1 = programmed), every request is granted. A table read returns `tbl_int_byte`. Outputs reflect the inputs sampled on the previous rising edge.
- R3: With `lock_bits` = 3'b001, the following are refused:
  - a table read with `tbl_ext_src` = 1, which returns 00H;
  - a program request.

  A table read with `tbl_ext_src` = 0 is granted with the internal byte. Verify and external-execution requests are granted.
- R4: With `lock_bits` = 3'b011, all refusals of R3 apply and verify is refused as well. External execution is still granted.
- R5: With `lock_bits` = 3'b111, all refusals of R4 apply and external execution is refused as well.
- R6: Any `lock_bits` value other than 000, 001, 011 and 111 behaves exactly like 111.
- R7: While `lock_bits[0]` = 0, `ea_eff` equals the `ext_pin` value sampled on the previous rising edge. Low means code is fetched externally from 0000H to FFFFH.
- R8: While `lock_bits[0]` = 1 and reset is low, `ea_eff` holds the `ext_pin` value sampled on the last clock edge with `rst` high. Later changes on `ext_pin` have no effect on it.
- R9: A cycle with no request gives no grant, and `tbl_data` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_bits | input | 3 | Lock bits; bit 0 is the first, 1 = programmed |
| ext_pin | input | 1 | Raw external-access strap, low = external code |
| tbl_req | input | 1 | Table read request |
| tbl_ext_src | input | 1 | The table read is issued by externally fetched code |
| tbl_int_byte | input | 8 | Byte read from internal code memory |
| prog_req | input | 1 | Flash program request |
| verify_req | input | 1 | Flash verify request |
| xexec_req | input | 1 | External execution request |
| tbl_grant | output | 1 | Table read granted |
| tbl_data | output | 8 | Returned byte, 00H when refused |
| prog_grant | output | 1 | Program granted |
| verify_grant | output | 1 | Verify granted |
| xexec_grant | output | 1 | External execution granted |
| ea_eff | output | 1 | Effective external-access level |

## Verification
A wrong level decode shows up at the grant ports one cycle after the request that hits it. For example, a 3'b010 pattern decoded as level one would wrongly grant verify on the very next edge. The bench therefore runs all eight lock patterns against every request.

A lost or wrongly loaded strap capture shows on `ea_eff` one cycle after the first non-reset edge with lock bit 0 set. The bench toggles `ext_pin` after reset to expose an output that follows the pin live.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;
  // Level at which each kind of access starts to be refused.
  localparam int TIER_TBL_EXT = 1;
  localparam int TIER_PROG    = 1;
  localparam int TIER_VERIFY  = 2;
  localparam int TIER_XEXEC   = 3;

  typedef struct packed {
    logic tbl_ext_ok;
    logic prog_ok;
    logic verify_ok;
    logic xexec_ok;
  } guard_perm_t;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import code_guard_pkg::*;
#(
  parameter int NUM_LOCK = 3
) (
  input  logic [NUM_LOCK-1:0] lock_bits,
  output guard_perm_t         perm
);
  localparam int CNT_W = $clog2(NUM_LOCK + 1);

  // is_therm[k]: exactly the low k lock bits are programmed.
  logic [NUM_LOCK:0] is_therm;
  logic [CNT_W-1:0]  lvl;

  genvar k;
  generate
    for (k = 0; k <= NUM_LOCK; k++) begin : g_therm
      assign is_therm[k] = (lock_bits == NUM_LOCK'((1 << k) - 1));
    end
  endgenerate

  // Illegal patterns fall through to the strictest level.
  always_comb begin
    lvl = CNT_W'(NUM_LOCK);
    for (int i = 0; i <= NUM_LOCK; i++) begin
      if (is_therm[i]) lvl = CNT_W'(i);
    end
  end

  always_comb begin
    perm.tbl_ext_ok = (lvl < CNT_W'(TIER_TBL_EXT));
    perm.prog_ok    = (lvl < CNT_W'(TIER_PROG));
    perm.verify_ok  = (lvl < CNT_W'(TIER_VERIFY));
    perm.xexec_ok   = (lvl < CNT_W'(TIER_XEXEC));
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic held
);
  // Capture only while reset is high; unknown until the first reset.
  always_ff @(posedge clk) begin
    if (rst) held <= pin;
  end
endmodule

// File: rtl/code_guard.sv
module code_guard
  import code_guard_pkg::*;
#(
  parameter int NUM_LOCK = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LOCK-1:0] lock_bits,
  input  logic                ext_pin,
  input  logic                tbl_req,
  input  logic                tbl_ext_src,
  input  logic [DATA_W-1:0]   tbl_int_byte,
  input  logic                prog_req,
  input  logic                verify_req,
  input  logic                xexec_req,
  output logic                tbl_grant,
  output logic [DATA_W-1:0]   tbl_data,
  output logic                prog_grant,
  output logic                verify_grant,
  output logic                xexec_grant,
  output logic                ea_eff
);
  guard_perm_t perm;
  logic        strap_held;
  logic        tbl_ok;

  guard_decode #(.NUM_LOCK(NUM_LOCK)) u_dec (
    .lock_bits (lock_bits),
    .perm      (perm)
  );

  strap_latch u_strap (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .held (strap_held)
  );

  assign tbl_ok = tbl_req && (!tbl_ext_src || perm.tbl_ext_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_grant    <= 1'b0;
      tbl_data     <= '0;
      prog_grant   <= 1'b0;
      verify_grant <= 1'b0;
      xexec_grant  <= 1'b0;
    end else begin
      tbl_grant    <= tbl_ok;
      tbl_data     <= tbl_ok ? tbl_int_byte : '0;
      prog_grant   <= prog_req && perm.prog_ok;
      verify_grant <= verify_req && perm.verify_ok;
      xexec_grant  <= xexec_req && perm.xexec_ok;
    end
  end

  // Live strap while the first lock bit is blank (or in reset), frozen copy otherwise.
  always_ff @(posedge clk) begin
    if (rst || !lock_bits[0]) ea_eff <= ext_pin;
    else                      ea_eff <= strap_held;
  end
endmodule

// File: rtl/code_guard_chk.sv
module code_guard_chk #(
  parameter int NUM_LOCK = 3,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_LOCK-1:0] lock_bits,
  input logic                ext_pin,
  input logic                tbl_grant,
  input logic [DATA_W-1:0]   tbl_data,
  input logic                prog_grant,
  input logic                verify_grant,
  input logic                xexec_grant,
  input logic                ea_eff
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!tbl_grant && !prog_grant && !verify_grant && !xexec_grant && tbl_data == '0));

  a_r3_prog_only_open: assert property (@(posedge clk) disable iff (rst)
    prog_grant |-> ($past(lock_bits) == '0));

  a_r4_verify_low_level: assert property (@(posedge clk) disable iff (rst)
    verify_grant |-> ($past(lock_bits) == NUM_LOCK'(0) || $past(lock_bits) == NUM_LOCK'(1)));

  a_r5_xexec_not_sealed: assert property (@(posedge clk) disable iff (rst)
    xexec_grant |-> ($past(lock_bits) == NUM_LOCK'(0) || $past(lock_bits) == NUM_LOCK'(1)
                     || $past(lock_bits) == NUM_LOCK'(3)));

  a_r9_refused_zero: assert property (@(posedge clk) disable iff (rst)
    !tbl_grant |-> (tbl_data == '0));

  a_r7_ea_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lock_bits[0])) |-> (ea_eff == $past(ext_pin)));

  a_r8_ea_frozen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lock_bits[0]) && !$past(rst, 2) && $past(lock_bits[0], 2))
      |-> $stable(ea_eff));
endmodule

bind code_guard code_guard_chk #(.NUM_LOCK(NUM_LOCK), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lock_bits    (lock_bits),
  .ext_pin      (ext_pin),
  .tbl_grant    (tbl_grant),
  .tbl_data     (tbl_data),
  .prog_grant   (prog_grant),
  .verify_grant (verify_grant),
  .xexec_grant  (xexec_grant),
  .ea_eff       (ea_eff)
);

// File: tb/sim_code_guard.sv
`timescale 1ns/1ps
module sim_code_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lock_bits = 3'b000;
  logic       ext_pin = 1'b1;
  logic       tbl_req = 1'b0, tbl_ext_src = 1'b0;
  logic [7:0] tbl_int_byte = 8'h00;
  logic       prog_req = 1'b0, verify_req = 1'b0, xexec_req = 1'b0;
  logic       tbl_grant, prog_grant, verify_grant, xexec_grant, ea_eff;
  logic [7:0] tbl_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  code_guard u0 (
    .clk(clk), .rst(rst), .lock_bits(lock_bits), .ext_pin(ext_pin),
    .tbl_req(tbl_req), .tbl_ext_src(tbl_ext_src), .tbl_int_byte(tbl_int_byte),
    .prog_req(prog_req), .verify_req(verify_req), .xexec_req(xexec_req),
    .tbl_grant(tbl_grant), .tbl_data(tbl_data), .prog_grant(prog_grant),
    .verify_grant(verify_grant), .xexec_grant(xexec_grant), .ea_eff(ea_eff)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Protection level from the requirements: legal patterns 000/001/011/111, else strictest.
  function automatic int level_of(logic [2:0] lb);
    case (lb)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b011:  return 2;
      default: return 3;
    endcase
  endfunction

  // Drive all requests for one cycle and check the registered answers.
  task automatic probe(string tag, logic [2:0] lb, logic ext_src, logic [7:0] byte_in);
    int lv = level_of(lb);
    bit t_ok = !ext_src || (lv < 1);
    @(negedge clk);
    lock_bits = lb; tbl_req = 1'b1; tbl_ext_src = ext_src; tbl_int_byte = byte_in;
    prog_req = 1'b1; verify_req = 1'b1; xexec_req = 1'b1;
    @(negedge clk);
    check({tag, " tbl_grant"}, {7'd0, tbl_grant}, {7'd0, t_ok});
    check({tag, " tbl_data"}, tbl_data, t_ok ? byte_in : 8'h00);
    check({tag, " prog"}, {7'd0, prog_grant}, {7'd0, lv < 1});
    check({tag, " verify"}, {7'd0, verify_grant}, {7'd0, lv < 2});
    check({tag, " xexec"}, {7'd0, xexec_grant}, {7'd0, lv < 3});
    tbl_req = 1'b0; prog_req = 1'b0; verify_req = 1'b0; xexec_req = 1'b0;
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk);
    rst = 1'b1; ext_pin = pin;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1; lock_bits = 3'b000; tbl_req = 1'b1; tbl_int_byte = 8'hA5;
    prog_req = 1'b1; verify_req = 1'b1; xexec_req = 1'b1; ext_pin = 1'b0;
    @(negedge clk);
    check("R1 tbl_grant", {7'd0, tbl_grant}, 8'd0);
    check("R1 tbl_data", tbl_data, 8'h00);
    check("R1 prog", {7'd0, prog_grant}, 8'd0);
    check("R1 verify", {7'd0, verify_grant}, 8'd0);
    check("R1 xexec", {7'd0, xexec_grant}, 8'd0);
    tbl_req = 1'b0; prog_req = 1'b0; verify_req = 1'b0; xexec_req = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_open();
    probe("R2 open ext", 3'b000, 1'b1, 8'h3C);
    probe("R2 open int", 3'b000, 1'b0, 8'hC3);
  endtask

  task automatic t_level1();
    probe("R3 lvl1 ext", 3'b001, 1'b1, 8'h5A);
    probe("R3 lvl1 int", 3'b001, 1'b0, 8'h77);
  endtask

  task automatic t_level2();
    probe("R4 lvl2 ext", 3'b011, 1'b1, 8'h11);
    probe("R4 lvl2 int", 3'b011, 1'b0, 8'h22);
  endtask

  task automatic t_level3();
    probe("R5 lvl3 ext", 3'b111, 1'b1, 8'h99);
    probe("R5 lvl3 int", 3'b111, 1'b0, 8'hEE);
  endtask

  task automatic t_illegal();
    probe("R6 pat010", 3'b010, 1'b0, 8'h01);
    probe("R6 pat100", 3'b100, 1'b1, 8'h02);
    probe("R6 pat101", 3'b101, 1'b0, 8'h04);
    probe("R6 pat110", 3'b110, 1'b0, 8'h08);
  endtask

  task automatic t_idle();
    @(negedge clk);
    lock_bits = 3'b000; tbl_int_byte = 8'hFF;
    tbl_req = 1'b0; prog_req = 1'b0; verify_req = 1'b0; xexec_req = 1'b0;
    @(negedge clk);
    check("R9 idle tbl_data", tbl_data, 8'h00);
    check("R9 idle grants", {4'd0, tbl_grant, prog_grant, verify_grant, xexec_grant}, 8'd0);
  endtask

  task automatic t_ea_follow();
    @(negedge clk);
    lock_bits = 3'b000; ext_pin = 1'b0;
    @(negedge clk);
    check("R7 follow low", {7'd0, ea_eff}, 8'd0);
    ext_pin = 1'b1;
    @(negedge clk);
    check("R7 follow high", {7'd0, ea_eff}, 8'd1);
    lock_bits = 3'b110; ext_pin = 1'b0;
    @(negedge clk);
    check("R7 follow bit0 blank", {7'd0, ea_eff}, 8'd0);
  endtask

  task automatic t_ea_latch();
    lock_bits = 3'b001;
    do_reset(1'b0);
    ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 frozen low", {7'd0, ea_eff}, 8'd0);
    lock_bits = 3'b000;
    @(negedge clk);
    check("R7 live again", {7'd0, ea_eff}, 8'd1);
    lock_bits = 3'b111;
    @(negedge clk);
    check("R8 back to held", {7'd0, ea_eff}, 8'd0);
    do_reset(1'b1);
    ext_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 frozen high", {7'd0, ea_eff}, 8'd1);
  endtask

  initial begin
    do_reset(1'b1);
    t_reset_state();
    t_open();
    t_level1();
    t_level2();
    t_level3();
    t_illegal();
    t_idle();
    t_ea_follow();
    t_ea_latch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule